// File: doc/BRIEF.md
# Signed/Unsigned Magnitude Comparator

This block compares two W-bit operands, `opA` and `opB`, with no clock and no storage. One adder forms the difference `opB - opA` as `opB + ~opA + 1`. The carry, zero, negative and overflow flags of that sum are driven out as raw flags. The ordering outputs are decoded from the same flags, so the signed and unsigned orderings share one subtractor rather than using two comparator trees. A mode input selects how the operands are read: as unsigned numbers or as two's complement numbers.

Equality does not go through the adder. It is found by XNOR-ing each bit pair and sending the results into an all-ones reduction tree. Two more reduction trees report whether `opA` is all ones or all zeros. The all-zeros detector is the all-ones tree fed with inverted bits.

Top module: `mag_compare_unit`

## Requirements
- R1: `flagCarry` is the carry out of `opB + ~opA + 1`. It is 1 exactly when `opB >= opA` read as unsigned numbers.
- R2: Let D = (`opB - opA`) mod 2^W. `flagZero` is 1 exactly when every bit of D is 0. `flagNeg` equals bit W-1 of D.
- R3: `flagOvf` is 1 exactly when bit W-1 of `opA` differs from bit W-1 of `opB` and bit W-1 of D differs from bit W-1 of `opB`.
- R4: `isEqual` is 1 exactly when `opA == opB`, in either mode.
- R5: With `signedMode` = 0, `isLess` is 1 exactly when `opA < opB`, both read as unsigned numbers. This case includes all-ones against zero.
- R6: With `signedMode` = 1, `isLess` is 1 exactly when `opA < opB`, both read as two's complement numbers. This case includes the most negative value against the most positive value.
- R7: In both modes, `isLessEq` equals `isLess | isEqual` and `isGreaterEq` equals `~isLess`.
- R8: `aAllOnes` is 1 exactly when every bit of `opA` is 1. `aAllZeros` is 1 exactly when every bit of `opA` is 0.
- R9: The four raw flags `flagCarry`, `flagZero`, `flagNeg` and `flagOvf` do not depend on `signedMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | W | First operand, the one subtracted |
| opB | input | W | Second operand |
| signedMode | input | 1 | 1 reads the operands as two's complement, 0 reads them as unsigned |
| isEqual | output | 1 | opA equals opB |
| isLess | output | 1 | opA is below opB in the selected mode |
| isLessEq | output | 1 | opA is at or below opB in the selected mode |
| isGreaterEq | output | 1 | opA is at or above opB in the selected mode |
| flagCarry | output | 1 | Carry out of the subtraction |
| flagZero | output | 1 | The difference is zero |
| flagNeg | output | 1 | Top bit of the difference |
| flagOvf | output | 1 | Signed overflow of the subtraction |
| aAllOnes | output | 1 | Every bit of opA is 1 |
| aAllZeros | output | 1 | Every bit of opA is 0 |

## Verification
The block is combinational, so an internal fault shows on the ports as soon as the inputs settle, within the same input vector. A wrong carry-in or a missing operand inversion gives a wrong difference, and then all four flags and the decoded ordering are wrong together. A swapped flag term in the ordering decode shows only in one mode. Operand pairs whose signs differ are the ones that expose it, because there the signed and unsigned orderings disagree. A broken reduction tree shows only on the rare input patterns where exactly one leaf decides the result, so the corner operands have to be applied directly.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  // Condition flags produced by the subtractor
  typedef struct packed {
    logic carry;
    logic zero;
    logic neg;
    logic ovf;
  } cmpFlags_t;

  // Strobes from control to datapath that set up the adder as a subtractor
  typedef struct packed {
    logic invertA;
    logic carryIn;
  } cmpStrobe_t;

endpackage

// File: rtl/magcmp_and_tree.sv
// Balanced AND reduction tree of log2 depth; unused leaves padded with 1.
module magcmp_and_tree #(
  parameter int W = 32
) (
  input  logic [W-1:0] leaves,
  output logic         allSet
);
  localparam int LEVELS = (W <= 1) ? 1 : $clog2(W);
  localparam int PADW   = 1 << LEVELS;

  logic [PADW-1:0] padded;

  always_comb begin
    padded = '1;
    padded[W-1:0] = leaves;
  end

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = PADW >> l;
    logic [CNT-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = padded;
    end else begin : g_node
      for (genvar i = 0; i < CNT; i++) begin : g_and
        assign v[i] = g_lvl[l-1].v[2*i] & g_lvl[l-1].v[2*i+1];
      end
    end
  end

  assign allSet = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/magcmp_datapath.sv
module magcmp_datapath
  import magcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  cmpStrobe_t   strobe,
  output cmpFlags_t    flags,
  output logic         isEqual,
  output logic         aAllOnes,
  output logic         aAllZeros
);
  localparam int MSB = W - 1;

  logic [W-1:0] addendA;
  logic [W:0]   sumFull;
  logic [W-1:0] diff;
  logic         diffZero;

  // Single adder: opB + (~opA) + 1 gives opB - opA
  assign addendA = strobe.invertA ? ~opA : opA;
  assign sumFull = {1'b0, opB} + {1'b0, addendA} + {{W{1'b0}}, strobe.carryIn};
  assign diff    = sumFull[W-1:0];

  // Zero flag: all-ones detect on the inverted difference
  magcmp_and_tree #(.W(W)) i_zeroTree (.leaves(~diff), .allSet(diffZero));

  // Equality: per-bit XNOR into an all-ones detector
  magcmp_and_tree #(.W(W)) i_eqTree (.leaves(~(opA ^ opB)), .allSet(isEqual));

  // Single-operand detectors
  magcmp_and_tree #(.W(W)) i_onesTree  (.leaves(opA),  .allSet(aAllOnes));
  magcmp_and_tree #(.W(W)) i_zerosTree (.leaves(~opA), .allSet(aAllZeros));

  always_comb begin
    flags.carry = sumFull[W];
    flags.zero  = diffZero;
    flags.neg   = diff[MSB];
    flags.ovf   = (opA[MSB] ^ opB[MSB]) & (diff[MSB] ^ opB[MSB]);
  end

endmodule

// File: rtl/magcmp_ctrl.sv
module magcmp_ctrl
  import magcmp_pkg::*;
(
  input  logic       signedMode,
  input  cmpFlags_t  flags,
  output cmpStrobe_t strobe,
  output logic       isLess,
  output logic       isLessEq,
  output logic       isGreaterEq
);
  logic unsignedLe;
  logic signedLe;
  logic orderLe;

  // Subtraction is always requested: invert A, carry in one
  assign strobe.invertA = 1'b1;
  assign strobe.carryIn = 1'b1;

  // D = B - A. Unsigned: carry set means B >= A. Signed: N xor V clear means B >= A.
  assign unsignedLe = flags.carry;
  assign signedLe   = ~(flags.neg ^ flags.ovf);
  assign orderLe    = signedMode ? signedLe : unsignedLe;

  assign isLessEq    = orderLe;
  assign isLess      = orderLe & ~flags.zero;
  assign isGreaterEq = ~isLess;

endmodule

// File: rtl/mag_compare_unit.sv
module mag_compare_unit
  import magcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         signedMode,
  output logic         isEqual,
  output logic         isLess,
  output logic         isLessEq,
  output logic         isGreaterEq,
  output logic         flagCarry,
  output logic         flagZero,
  output logic         flagNeg,
  output logic         flagOvf,
  output logic         aAllOnes,
  output logic         aAllZeros
);
  cmpFlags_t  flags;
  cmpStrobe_t strobe;

  magcmp_datapath #(.W(W)) i_datapath (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .flags    (flags),
    .isEqual  (isEqual),
    .aAllOnes (aAllOnes),
    .aAllZeros(aAllZeros)
  );

  magcmp_ctrl i_ctrl (
    .signedMode (signedMode),
    .flags      (flags),
    .strobe     (strobe),
    .isLess     (isLess),
    .isLessEq   (isLessEq),
    .isGreaterEq(isGreaterEq)
  );

  assign flagCarry = flags.carry;
  assign flagZero  = flags.zero;
  assign flagNeg   = flags.neg;
  assign flagOvf   = flags.ovf;

endmodule

// File: rtl/mag_compare_checker.sv
module mag_compare_checker #(
  parameter int W = 32
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         signedMode,
  input logic         isEqual,
  input logic         isLess,
  input logic         isLessEq,
  input logic         isGreaterEq,
  input logic         flagCarry,
  input logic         flagZero,
  input logic         flagNeg,
  input logic         flagOvf,
  input logic         aAllOnes,
  input logic         aAllZeros
);
  always_comb begin
    // R2 and R4: zero flag from the adder agrees with the XNOR equality tree
    assert_zero_matches_eq_R4: assert (flagZero == isEqual)
      else $error("zero flag and equality disagree");
    // R7: less-or-equal is less or equal
    assert_le_is_lt_or_eq_R7: assert (isLessEq == (isLess | isEqual))
      else $error("isLessEq inconsistent");
    // R7: greater-or-equal is the complement of less
    assert_ge_not_lt_R7: assert (isGreaterEq != isLess)
      else $error("isGreaterEq inconsistent");
    // R3: overflow only when the operand signs differ
    assert_ovf_needs_sign_split_R3: assert (!flagOvf || (opA[W-1] != opB[W-1]))
      else $error("overflow with equal operand signs");
    // R8: an operand cannot be all ones and all zeros at once
    assert_detectors_exclusive_R8: assert (!(aAllOnes && aAllZeros))
      else $error("both detectors set");
    // R5: in unsigned mode ordering follows the carry
    assert_unsigned_le_carry_R5: assert (signedMode || (isLessEq == flagCarry))
      else $error("unsigned ordering not carry");
    // R6: in signed mode ordering follows N xor V
    assert_signed_le_nv_R6: assert (!signedMode || (isLessEq == !(flagNeg ^ flagOvf)))
      else $error("signed ordering not N xor V");
  end
endmodule

bind mag_compare_unit mag_compare_checker #(.W(W)) i_checker (
  .opA(opA), .opB(opB), .signedMode(signedMode),
  .isEqual(isEqual), .isLess(isLess), .isLessEq(isLessEq), .isGreaterEq(isGreaterEq),
  .flagCarry(flagCarry), .flagZero(flagZero), .flagNeg(flagNeg), .flagOvf(flagOvf),
  .aAllOnes(aAllOnes), .aAllZeros(aAllZeros)
);

// File: tb/test_mag_compare_unit.sv
`timescale 1ns/1ps
module test_mag_compare_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] opA, opB;
  logic signedMode;
  logic isEqual, isLess, isLessEq, isGreaterEq;
  logic flagCarry, flagZero, flagNeg, flagOvf, aAllOnes, aAllZeros;

  int checks = 0;
  int errors = 0;

  mag_compare_unit #(.W(W)) i_mag_compare_unit (
    .opA(opA), .opB(opB), .signedMode(signedMode),
    .isEqual(isEqual), .isLess(isLess), .isLessEq(isLessEq), .isGreaterEq(isGreaterEq),
    .flagCarry(flagCarry), .flagZero(flagZero), .flagNeg(flagNeg), .flagOvf(flagOvf),
    .aAllOnes(aAllOnes), .aAllZeros(aAllZeros)
  );

  function automatic logic refLess(input logic [W-1:0] a, input logic [W-1:0] b, input logic sm);
    return sm ? ($signed(a) < $signed(b)) : (a < b);
  endfunction

  function automatic logic refOvf(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    d = b - a;
    return (a[W-1] != b[W-1]) && (d[W-1] != b[W-1]);
  endfunction

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (a=%h b=%h mode=%b)",
               tag, what, act, exp, opA, opB, signedMode);
    end
  endtask

  task automatic applyPair(input logic [W-1:0] a, input logic [W-1:0] b, input logic sm);
    logic [W-1:0] d;
    logic lt, eq;
    @(negedge clk);
    opA = a; opB = b; signedMode = sm;
    #1;
    d  = b - a;
    lt = refLess(a, b, sm);
    eq = (a == b);
    checkBit("R1", "flagCarry", flagCarry, b >= a);
    checkBit("R2", "flagZero", flagZero, d == '0);
    checkBit("R2", "flagNeg", flagNeg, d[W-1]);
    checkBit("R3", "flagOvf", flagOvf, refOvf(a, b));
    checkBit("R4", "isEqual", isEqual, eq);
    checkBit(sm ? "R6" : "R5", "isLess", isLess, lt);
    checkBit("R7", "isLessEq", isLessEq, lt | eq);
    checkBit("R7", "isGreaterEq", isGreaterEq, !lt);
    checkBit("R8", "aAllOnes", aAllOnes, a == '1);
    checkBit("R8", "aAllZeros", aAllZeros, a == '0);
  endtask

  // R9: flags identical in both modes for the same pair
  task automatic modeIndependence(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [3:0] f0;
    @(negedge clk);
    opA = a; opB = b; signedMode = 1'b0;
    #1 f0 = {flagCarry, flagZero, flagNeg, flagOvf};
    signedMode = 1'b1;
    #1;
    checks++;
    if ({flagCarry, flagZero, flagNeg, flagOvf} !== f0) begin
      errors++;
      $display("FAIL R9 flags vs mode: actual %b expected %b",
               {flagCarry, flagZero, flagNeg, flagOvf}, f0);
    end
  endtask

  task automatic bothModes(input logic [W-1:0] a, input logic [W-1:0] b);
    applyPair(a, b, 1'b0);
    applyPair(a, b, 1'b1);
    modeIndependence(a, b);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] minNeg, maxPos;
    int seed;
    minNeg = {1'b1, {(W-1){1'b0}}};
    maxPos = {1'b0, {(W-1){1'b1}}};
    seed = 32'h5eed1234;
    void'($urandom(seed));
    opA = '0; opB = '0; signedMode = 1'b0;
    // Initial state: all-zero operands
    applyPair('0, '0, 1'b0);
    // Directed corners
    bothModes('1, '1);
    bothModes(minNeg, maxPos);
    bothModes(maxPos, minNeg);
    bothModes('1, '0);
    bothModes('0, '1);
    bothModes(32'd1, 32'd0);
    bothModes(32'd0, 32'd1);
    bothModes(minNeg, minNeg);
    bothModes(minNeg, 32'd0);
    bothModes(32'd0, minNeg);
    bothModes(32'hFFFF_FFFE, '1);
    bothModes(32'h7FFF_FFFE, 32'h0000_0001);
    // Random pairs, some with shared upper bits to reach near-equal values
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 4 == 0) rb = {ra[W-1:4], rb[3:0]};
      if (i % 7 == 0) rb = ra;
      bothModes(ra, rb);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule